// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block creates the frame synchronization strobe of a framed serial port that runs in SPI or TDM fashion. It is clocked by the bit clock, so one clock cycle is one bit time. It counts bits into slots and slots into frames. From that count it produces a slot index, a strobe on the first bit of every slot, and a word-valid flag that marks the data bits inside a slot. A neighbouring shifter uses these to place data in the frame.

In host mode the block drives the sync line. The active level, the width of the pulse and the position of its leading edge are all programmable. The leading edge can fall on the first data bit or one bit time before it. In client mode the sync line is an input. Its active edge realigns the counters. An edge that arrives away from the expected frame boundary raises a sticky flag. Encoded settings are captured only while the port is disabled. A reserved code falls back to the largest legal value of its field and raises a sticky configuration error.

Top module: `tdm_fsync_gen`

## Requirements
- R1: The slot length in bits is 8 + 4*code for slot-size codes 0 to 6, and 32 for code 7. While the port runs, `slot_first` is 1 exactly on bit 0 of every slot.
- R2: The number of slots per frame is 1 for frame code 0, code+1 for codes 1 to 4, 2*code-4 for codes 5 to 18, and 32 for codes 19 to 31. `slot_idx` counts 0 to N-1 within the frame and then wraps to 0.
- R3: In host mode the sync is active for W bit times per frame. W is 1 for width code 0. W is code*slot-length for codes 1 to 7. W is 8, 16 or 32 slot lengths for codes 8, 9 and 10, and 32 slot lengths for codes 11 to 15. If W reaches the frame length, the sync stays active.
- R4: With the edge select at 1, the active window starts on bit 0 of slot 0. With it at 0, the window starts one bit time earlier, on the last bit of the previous frame. After enable in this mode, the first bit time is such a lead-in bit.
- R5: The sync is at level `cfg_pol` while active and at the inverse level otherwise, and also while the port is disabled. Polarity 1 is active high and polarity 0 is active low.
- R6: Direction 0 (host) sets `fsync_oe` to 1. Direction 1 (client) sets `fsync_oe` to 0, and `fsync_o` then holds the idle level.
- R7: A configuration write (`cfg_we`) is captured only while `port_en` is 0. A write made while the port is enabled has no effect on later behaviour.
- R8: When an accepted write carries a reserved code, the field takes its largest value and `cfg_err` sets to 1. The reserved codes are word or slot size 7, frame code above 18, and width code above 10. The flag stays set until reset.
- R9: `word_valid` is 1 on bits 0 to B-1 of every slot while the port runs, where B is the word length. The word length uses the same encoding as R1 and is capped by the slot length.
- R10: In client mode after enable, `slot_first` and `word_valid` stay 0 until the first active edge of `fsync_i`. With the edge select at 1, the edge cycle is bit 0 of slot 0. With it at 0, the edge cycle is the last bit of the frame, and slot 0 starts in the next cycle.
- R11: A client edge at the expected frame boundary leaves `resync_err` unchanged. An edge anywhere else restarts the counters from that edge, and `resync_err` is 1 from the following cycle until reset.
- R12: After reset, the configuration is all-zero codes (host, active low). `fsync_o` is 1, `fsync_oe` is 1, and `slot_first`, `word_valid`, `cfg_err` and `resync_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; configuration is locked while 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word_sz | input | 3 | Word length code |
| cfg_slot_sz | input | 3 | Slot length code |
| cfg_frame_cnt | input | 5 | Slots-per-frame code |
| cfg_width | input | 4 | Sync width code |
| cfg_pol | input | 1 | Sync active level (1 = high) |
| cfg_coinc | input | 1 | 1 = edge on first bit, 0 = one bit earlier |
| cfg_client | input | 1 | 1 = sync is an input |
| fsync_i | input | 1 | Sync line input (client mode) |
| fsync_o | output | 1 | Sync line output value |
| fsync_oe | output | 1 | Sync line output enable |
| slot_idx | output | 5 | Current slot within the frame |
| slot_first | output | 1 | First bit of a slot |
| word_valid | output | 1 | Bit lies inside the data word of the slot |
| cfg_err | output | 1 | Sticky reserved-code flag |
| resync_err | output | 1 | Sticky misaligned client edge flag |

## Verification
The hardest state to reach is a client edge that lands off the frame boundary after the counters are already locked. At the same time, the first edge that locks the counters must not count as a fault. The stimulus drives `fsync_i` at chosen bit offsets from the locking edge: once exactly one frame later, and once five bits after that. It then follows the new alignment cycle by cycle. The one-bit lead-in of the early-edge mode is the second difficult case, because it begins in the very first enabled cycle. Randomly drawn legal configurations in both edge modes reach it, and so does a directed early-edge client run.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;

  localparam int MAX_SLOT_BITS   = 32;
  localparam int MAX_SLOTS       = 32;
  localparam int MAX_WIDTH_WORDS = 32;

  localparam int SB_W   = $clog2(MAX_SLOT_BITS + 1);
  localparam int BIT_W  = $clog2(MAX_SLOT_BITS);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int FS_W   = $clog2(MAX_SLOTS + 1);
  localparam int WW_W   = $clog2(MAX_WIDTH_WORDS + 1);
  localparam int MAX_MUL = (MAX_SLOTS > MAX_WIDTH_WORDS) ? MAX_SLOTS : MAX_WIDTH_WORDS;
  localparam int CMP_W  = $clog2(MAX_SLOT_BITS * MAX_MUL + 1) + 1;

  typedef struct packed {
    logic [2:0] word_code;
    logic [2:0] slot_code;
    logic [4:0] frame_code;
    logic [3:0] width_code;
    logic       pol;
    logic       coinc;
    logic       client;
  } cfg_codes_t;

  // bits per slot or word: 8 + 4*code, reserved code saturates
  function automatic logic [SB_W-1:0] size_bits_of(input logic [2:0] code);
    if (code == 3'd7) return SB_W'(MAX_SLOT_BITS);
    return SB_W'(8 + 4 * int'(code));
  endfunction

  function automatic logic [FS_W-1:0] frame_slots_of(input logic [4:0] code);
    int c;
    c = int'(code);
    if (c == 0)  return FS_W'(1);
    if (c <= 4)  return FS_W'(c + 1);
    if (c <= 18) return FS_W'(2 * c - 4);
    return FS_W'(MAX_SLOTS);
  endfunction

  // zero means a single bit-clock pulse
  function automatic logic [WW_W-1:0] width_words_of(input logic [3:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return WW_W'(code);
      4'd8:    return WW_W'(8);
      4'd9:    return WW_W'(16);
      default: return WW_W'(MAX_WIDTH_WORDS);
    endcase
  endfunction

  function automatic logic codes_reserved(input cfg_codes_t c);
    return (c.word_code == 3'd7) || (c.slot_code == 3'd7) ||
           (c.frame_code > 5'd18) || (c.width_code > 4'd10);
  endfunction

endpackage

// File: rtl/tdm_fsync_cfg.sv
module tdm_fsync_cfg
  import tdm_fsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             cfg_we,
  input  cfg_codes_t       cfg_in,
  output cfg_codes_t       codes,
  output logic [SB_W-1:0]  slot_bits,
  output logic [SB_W-1:0]  word_bits,
  output logic [FS_W-1:0]  frame_slots,
  output logic [WW_W-1:0]  width_words,
  output logic             cfg_err
);

  cfg_codes_t codes_q, codes_d;
  logic       err_q, err_d;
  logic       wr_ok;

  always_comb begin
    wr_ok   = cfg_we & ~port_en;
    codes_d = codes_q;
    err_d   = err_q;
    if (wr_ok) begin
      codes_d = cfg_in;
      err_d   = err_q | codes_reserved(cfg_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      codes_q <= codes_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    codes       = codes_q;
    slot_bits   = size_bits_of(codes_q.slot_code);
    word_bits   = size_bits_of(codes_q.word_code);
    frame_slots = frame_slots_of(codes_q.frame_code);
    width_words = width_words_of(codes_q.width_code);
    cfg_err     = err_q;
  end

endmodule

// File: rtl/tdm_fsync_cnt.sv
module tdm_fsync_cnt
  import tdm_fsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              client,
  input  logic              coinc,
  input  logic              pol,
  input  logic              fsync_i,
  input  logic [SB_W-1:0]   slot_bits,
  input  logic [FS_W-1:0]   frame_slots,
  output logic              run,
  output logic [BIT_W-1:0]  bit_pos,
  output logic [SLOT_W-1:0] slot_pos,
  output logic              resync_err
);

  logic [BIT_W-1:0]  bit_q, bit_d, bit_start;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_start;
  logic              run_q, run_d;
  logic              prev_q, prev_d;
  logic              rsy_q, rsy_d;
  logic              act, lead, at_start, bit_wrap, slot_wrap;

  always_comb begin
    // frame start position: bit 0 of slot 0, or the last bit before it
    bit_start  = coinc ? '0 : BIT_W'(slot_bits - SB_W'(1));
    slot_start = coinc ? '0 : SLOT_W'(frame_slots - FS_W'(1));

    act      = ~(fsync_i ^ pol);
    lead     = en & client & act & ~prev_q;
    at_start = (bit_q == bit_start) && (slot_q == slot_start);
    run      = en & (~client | run_q | lead);

    bit_pos  = lead ? bit_start  : bit_q;
    slot_pos = lead ? slot_start : slot_q;

    bit_wrap  = (SB_W'(bit_pos) == slot_bits - SB_W'(1));
    slot_wrap = (FS_W'(slot_pos) == frame_slots - FS_W'(1));

    bit_d  = bit_q;
    slot_d = slot_q;
    run_d  = run_q;
    if (!en) begin
      bit_d  = bit_start;
      slot_d = slot_start;
      run_d  = 1'b0;
    end else if (run) begin
      run_d = 1'b1;
      if (bit_wrap) begin
        bit_d  = '0;
        slot_d = slot_wrap ? '0 : slot_pos + 1'b1;
      end else begin
        bit_d  = bit_pos + 1'b1;
        slot_d = slot_pos;
      end
    end

    prev_d = act;
    rsy_d  = rsy_q | (lead & run_q & ~at_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
      prev_q <= 1'b0;
      rsy_q  <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
      run_q  <= run_d;
      prev_q <= prev_d;
      rsy_q  <= rsy_d;
    end
  end

  assign resync_err = rsy_q;

endmodule

// File: rtl/tdm_fsync_out.sv
module tdm_fsync_out
  import tdm_fsync_pkg::*;
(
  input  logic              run,
  input  logic              client,
  input  logic              coinc,
  input  logic              pol,
  input  logic [BIT_W-1:0]  bit_pos,
  input  logic [SLOT_W-1:0] slot_pos,
  input  logic [SB_W-1:0]   slot_bits,
  input  logic [SB_W-1:0]   word_bits,
  input  logic [FS_W-1:0]   frame_slots,
  input  logic [WW_W-1:0]   width_words,
  output logic              fsync_o,
  output logic              fsync_oe,
  output logic              slot_first,
  output logic              word_valid,
  output logic [SLOT_W-1:0] slot_idx
);

  logic [CMP_W-1:0] pos, flen, wlen;
  logic             hit;

  always_comb begin
    pos  = CMP_W'(slot_pos) * CMP_W'(slot_bits) + CMP_W'(bit_pos);
    flen = CMP_W'(frame_slots) * CMP_W'(slot_bits);
    wlen = (width_words == '0) ? CMP_W'(1)
                               : CMP_W'(width_words) * CMP_W'(slot_bits);
    if (coinc) hit = (pos < wlen);
    else       hit = (pos == flen - CMP_W'(1)) || (pos + CMP_W'(1) < wlen);

    fsync_o    = (run & ~client & hit) ? pol : ~pol;
    fsync_oe   = ~client;
    slot_first = run & (bit_pos == '0);
    word_valid = run & (SB_W'(bit_pos) < word_bits);
    slot_idx   = run ? slot_pos : '0;
  end

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       cfg_we,
  input  logic [2:0] cfg_word_sz,
  input  logic [2:0] cfg_slot_sz,
  input  logic [4:0] cfg_frame_cnt,
  input  logic [3:0] cfg_width,
  input  logic       cfg_pol,
  input  logic       cfg_coinc,
  input  logic       cfg_client,
  input  logic       fsync_i,
  output logic       fsync_o,
  output logic       fsync_oe,
  output logic [4:0] slot_idx,
  output logic       slot_first,
  output logic       word_valid,
  output logic       cfg_err,
  output logic       resync_err
);

  cfg_codes_t        cfg_in, codes;
  logic [SB_W-1:0]   slot_bits, word_bits;
  logic [FS_W-1:0]   frame_slots;
  logic [WW_W-1:0]   width_words;
  logic              run;
  logic [BIT_W-1:0]  bit_pos;
  logic [SLOT_W-1:0] slot_pos;
  logic [SLOT_W-1:0] idx_w;
  logic              pol_q, coinc_q, client_q;

  always_comb begin
    cfg_in.word_code  = cfg_word_sz;
    cfg_in.slot_code  = cfg_slot_sz;
    cfg_in.frame_code = cfg_frame_cnt;
    cfg_in.width_code = cfg_width;
    cfg_in.pol        = cfg_pol;
    cfg_in.coinc      = cfg_coinc;
    cfg_in.client     = cfg_client;
    pol_q    = codes.pol;
    coinc_q  = codes.coinc;
    client_q = codes.client;
  end

  tdm_fsync_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_we(cfg_we),
    .cfg_in(cfg_in), .codes(codes), .slot_bits(slot_bits),
    .word_bits(word_bits), .frame_slots(frame_slots),
    .width_words(width_words), .cfg_err(cfg_err)
  );

  tdm_fsync_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .en(port_en), .client(client_q),
    .coinc(coinc_q), .pol(pol_q), .fsync_i(fsync_i),
    .slot_bits(slot_bits), .frame_slots(frame_slots), .run(run),
    .bit_pos(bit_pos), .slot_pos(slot_pos), .resync_err(resync_err)
  );

  tdm_fsync_out u_out (
    .run(run), .client(client_q), .coinc(coinc_q), .pol(pol_q),
    .bit_pos(bit_pos), .slot_pos(slot_pos), .slot_bits(slot_bits),
    .word_bits(word_bits), .frame_slots(frame_slots),
    .width_words(width_words), .fsync_o(fsync_o), .fsync_oe(fsync_oe),
    .slot_first(slot_first), .word_valid(word_valid), .slot_idx(idx_w)
  );

  assign slot_idx = 5'(idx_w);

endmodule

// File: rtl/tdm_fsync_chk.sv
module tdm_fsync_chk
  import tdm_fsync_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            port_en,
  input logic            fsync_o,
  input logic            fsync_oe,
  input logic            slot_first,
  input logic [4:0]      slot_idx,
  input logic            word_valid,
  input logic            cfg_err,
  input logic            resync_err,
  input logic            pol,
  input logic            coinc,
  input logic            client,
  input logic [FS_W-1:0] frame_slots,
  input logic [SB_W-1:0] slot_bits
);

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    FS_W'(slot_idx) < frame_slots);

  p_coinc_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!client && coinc && slot_first && slot_idx == 5'd0) |-> (fsync_o == pol));

  p_lead_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en) && !client && !coinc && slot_first && slot_idx == 5'd0)
      |-> $past(fsync_o == pol));

  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!slot_first && !word_valid && fsync_o == !pol));

  p_client_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_oe |-> (fsync_o == !pol));

  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en)) |->
      ($stable(slot_bits) && $stable(frame_slots) && $stable(pol) && $stable(client)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_first_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_first |-> word_valid);

  p_resync_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resync_err |=> resync_err);

  p_resync_client_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync_err) |-> $past(client && port_en));

endmodule

bind tdm_fsync_gen tdm_fsync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .fsync_o(fsync_o),
  .fsync_oe(fsync_oe), .slot_first(slot_first), .slot_idx(slot_idx),
  .word_valid(word_valid), .cfg_err(cfg_err), .resync_err(resync_err),
  .pol(pol_q), .coinc(coinc_q), .client(client_q),
  .frame_slots(frame_slots), .slot_bits(slot_bits)
);

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 20250611;

  logic       clk, rst_n, port_en, cfg_we;
  logic [2:0] cfg_word_sz, cfg_slot_sz;
  logic [4:0] cfg_frame_cnt;
  logic [3:0] cfg_width;
  logic       cfg_pol, cfg_coinc, cfg_client, fsync_i;
  logic       fsync_o, fsync_oe, slot_first, word_valid, cfg_err, resync_err;
  logic [4:0] slot_idx;

  int n_tests;
  int n_fail;

  tdm_fsync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_we(cfg_we),
    .cfg_word_sz(cfg_word_sz), .cfg_slot_sz(cfg_slot_sz),
    .cfg_frame_cnt(cfg_frame_cnt), .cfg_width(cfg_width),
    .cfg_pol(cfg_pol), .cfg_coinc(cfg_coinc), .cfg_client(cfg_client),
    .fsync_i(fsync_i), .fsync_o(fsync_o), .fsync_oe(fsync_oe),
    .slot_idx(slot_idx), .slot_first(slot_first), .word_valid(word_valid),
    .cfg_err(cfg_err), .resync_err(resync_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R12: run did not finish, got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int b_size(input int c);
    case (c)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      4: return 24;
      5: return 28;
      default: return 32;
    endcase
  endfunction

  function automatic int b_frame(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return (c <= 18) ? 6 + 2 * (c - 5) : 32;
    endcase
  endfunction

  function automatic int b_wbits(input int c, input int sb);
    if (c == 0) return 1;
    if (c <= 7) return c * sb;
    if (c == 8) return 8 * sb;
    if (c == 9) return 16 * sb;
    return 32 * sb;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input int wc, input int sc, input int fc, input int wdc,
                           input bit pl, input bit co, input bit cl);
    @(negedge clk);
    cfg_word_sz   = 3'(wc);
    cfg_slot_sz   = 3'(sc);
    cfg_frame_cnt = 5'(fc);
    cfg_width     = 4'(wdc);
    cfg_pol       = pl;
    cfg_coinc     = co;
    cfg_client    = cl;
    cfg_we        = 1'b1;
    @(negedge clk);
    cfg_we        = 1'b0;
  endtask

  // host run: n counts bit times from the first enabled cycle
  task automatic run_host(input int sb, input int wb, input int ns, input int wbits,
                          input bit co, input bit pl, input int ncyc, input string tag);
    int flen, pos, bi;
    bit hit;
    flen = sb * ns;
    @(negedge clk);
    port_en = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      #1;
      pos = co ? (n % flen) : ((n + flen - 1) % flen);
      bi  = pos % sb;
      hit = co ? (pos < wbits) : (((pos + 1) % flen) < wbits);
      check({tag, " R1 slot_first"}, int'(slot_first), int'(bi == 0));
      check({tag, " R2 slot_idx"}, int'(slot_idx), pos / sb);
      check({tag, " R9 word_valid"}, int'(word_valid), int'(bi < wb));
      check({tag, " R3/R4/R5 fsync_o"}, int'(fsync_o), int'(hit ? pl : !pl));
      @(negedge clk);
    end
    port_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int sc, wc, fc, wdc, sb, ns, ncyc, origin, pos;
    bit pl, co;
    n_tests = 0;
    n_fail  = 0;
    void'($urandom(SEED));
    rst_n = 1'b0; port_en = 1'b0; cfg_we = 1'b0; fsync_i = 1'b0;
    cfg_word_sz = '0; cfg_slot_sz = '0; cfg_frame_cnt = '0; cfg_width = '0;
    cfg_pol = 1'b0; cfg_coinc = 1'b0; cfg_client = 1'b0;
    do_reset();

    // R12 reset state
    #1;
    check("R12 fsync_o", int'(fsync_o), 1);
    check("R12 fsync_oe", int'(fsync_oe), 1);
    check("R12 slot_first", int'(slot_first), 0);
    check("R12 word_valid", int'(word_valid), 0);
    check("R12 cfg_err", int'(cfg_err), 0);
    check("R12 resync_err", int'(resync_err), 0);

    // directed host cases
    write_cfg(0, 0, 1, 0, 1'b1, 1'b1, 1'b0);
    run_host(8, 8, 2, 1, 1'b1, 1'b1, 40, "coinc");
    #1 check("R5 disabled idle pol=1", int'(fsync_o), 0);
    write_cfg(0, 0, 1, 0, 1'b1, 1'b0, 1'b0);
    run_host(8, 8, 2, 1, 1'b0, 1'b1, 40, "lead");
    write_cfg(0, 1, 4, 2, 1'b0, 1'b1, 1'b0);
    run_host(12, 8, 5, 24, 1'b1, 1'b0, 130, "wide");
    write_cfg(6, 0, 3, 1, 1'b0, 1'b0, 1'b0);
    run_host(8, 32, 4, 8, 1'b0, 1'b0, 70, "R9 capped");
    write_cfg(0, 6, 2, 9, 1'b1, 1'b1, 1'b0);
    run_host(32, 8, 3, 512, 1'b1, 1'b1, 200, "R9 short");

    // R7: write while enabled is ignored
    write_cfg(0, 0, 1, 0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    port_en = 1'b1;
    write_cfg(3, 3, 5, 3, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    #1 check("R7 direction kept", int'(fsync_oe), 1);
    check("R7 cfg_err unchanged", int'(cfg_err), 0);
    run_host(8, 8, 2, 1, 1'b1, 1'b1, 40, "R7 old cfg");

    // R8 reserved codes saturate and flag
    write_cfg(7, 7, 31, 15, 1'b1, 1'b1, 1'b0);
    #1 check("R8 cfg_err set", int'(cfg_err), 1);
    run_host(32, 32, 32, 1024, 1'b1, 1'b1, 70, "R8 max");
    write_cfg(0, 0, 1, 0, 1'b0, 1'b1, 1'b0);
    #1 check("R8 cfg_err sticky", int'(cfg_err), 1);
    do_reset();
    #1 check("R8/R12 cfg_err cleared by reset", int'(cfg_err), 0);

    // random legal host configurations
    for (int k = 0; k < 14; k++) begin
      sc  = int'($urandom % 7);
      wc  = int'($urandom % 7);
      fc  = int'($urandom % 19);
      wdc = int'($urandom % 11);
      pl  = 1'($urandom % 2);
      co  = 1'($urandom % 2);
      sb  = b_size(sc);
      ns  = b_frame(fc);
      ncyc = 2 * sb * ns + 2;
      if (ncyc > 1500) ncyc = 1500;
      write_cfg(wc, sc, fc, wdc, pl, co, 1'b0);
      run_host(sb, b_size(wc), ns, b_wbits(wdc, sb), co, pl, ncyc, "rand");
    end

    // client mode, edge on first bit: slots of 8, 2 per frame
    write_cfg(0, 0, 1, 0, 1'b1, 1'b1, 1'b1);
    #1 check("R6 fsync_oe client", int'(fsync_oe), 0);
    check("R6 fsync_o idle client", int'(fsync_o), 0);
    @(negedge clk);
    port_en = 1'b1;
    for (int n = 0; n < 5; n++) begin
      #1 check("R10 no strobe before edge", int'(slot_first), 0);
      check("R10 no word before edge", int'(word_valid), 0);
      @(negedge clk);
    end
    origin = 0;
    for (int n = 0; n < 40; n++) begin
      fsync_i = (n == 0 || n == 16 || n == 21);
      if (n == 21) origin = 21;
      #1;
      pos = (n - origin) % 16;
      check("R10/R11 client slot_first", int'(slot_first), int'(pos % 8 == 0));
      check("R10/R11 client slot_idx", int'(slot_idx), pos / 8);
      check("R6 fsync_o idle while client", int'(fsync_o), 0);
      if (n == 20) check("R11 aligned edge no flag", int'(resync_err), 0);
      if (n == 22) check("R11 misaligned edge flag", int'(resync_err), 1);
      @(negedge clk);
    end
    fsync_i = 1'b0;
    port_en = 1'b0;
    do_reset();

    // client mode, edge one bit before first bit, active low
    fsync_i = 1'b1;
    write_cfg(0, 0, 1, 0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    port_en = 1'b1;
    for (int n = 0; n < 36; n++) begin
      fsync_i = !(n == 3 || n == 19);
      #1;
      if (n < 3) begin
        check("R10 lead client idle", int'(slot_first), 0);
      end else begin
        pos = (n - 3 + 15) % 16;
        check("R10 lead client slot_first", int'(slot_first), int'(pos % 8 == 0));
        check("R10 lead client slot_idx", int'(slot_idx), pos / 8);
      end
      @(negedge clk);
    end
    #1 check("R11 lead aligned no flag", int'(resync_err), 0);
    port_en = 1'b0;
    fsync_i = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule